// File: doc/BRIEF.md
# Serial Link Test Pattern Generator

This block sits on the transmit side of a serial link and can replace the normal data with test data. A 4-bit mode code selects one of these sources: a constant checkerboard word, a word that toggles between all ones and all zeros, one of four pseudorandom bit sequences (PRBS7, PRBS9, PRBS15 or PRBS23), or a set of four user words. The user words can be sent either as a repeating cycle or once only. A 2-bit injection code selects where the test data enters the link. It can go in as 8-bit words ahead of the scrambler or as 10-bit words after the line encoder. The scrambler, the encoder and the serializer are outside this block.

A separate invert control complements every bit of the 10-bit line word on its way to the serializer. It acts on both test data and normal data. A mode code that is not listed selects no test data, so both outputs carry the normal data. A change of mode code restarts the newly selected sequence in the same cycle. A one-cycle start strobe restarts the user-word sequence.

Top module: `tpg_top`

## Requirements
- R1: Out of reset, with mode 0000, the byte output equals the byte-path input and the line output equals the line-path input (complemented when invert is high).
- R2: Injection code 10 puts the 8-bit test word on the byte output and leaves the line output on normal data. Code 01 puts the 10-bit test word on the line output and leaves the byte output on normal data. Codes 00 and 11 inject nothing.
- R3: Mode 0001 outputs a constant checkerboard word whose MSB is 1 and whose bits alternate below it: 8'hAA on the byte path and 10'h2AA on the line path.
- R4: Mode 0010 outputs all ones in the first cycle after the mode is entered, then all zeros, and alternates every cycle after that.
- R5: Modes 1100, 0100, 1101 and 0011 select PRBS7 (x^7+x^6+1), PRBS9 (x^9+x^5+1), PRBS15 (x^15+x^14+1) and PRBS23 (x^23+x^18+1). An N-bit register seeded with all ones shifts left, and the new bit is the XOR of state bits N-1 and B-1 (B is the middle exponent). Each cycle produces as many new bits as the word width, and the first new bit is placed in the MSB.
- R6: Mode 0101 outputs user words 1, 2, 3, 4, one per cycle, and then repeats. Word 1 appears in the cycle the mode is entered or a start strobe is seen.
- R7: Mode 0110 outputs user words 1 to 4 once, one per cycle, and then all zeros. A start strobe restarts the sequence from word 1 in that same cycle.
- R8: Each 16-bit user word contributes its top 8 bits on the byte path and its top 10 bits on the line path.
- R9: When invert is high, all 10 bits of the line output are complemented in every mode and for every injection code.
- R10: Mode codes 0111, 1000 to 1011, 1110 and 1111 inject nothing, so both outputs pass normal data.
- R11: A change of mode code reseeds the PRBS, resets the toggle phase and rewinds the user word index, all in the cycle of the change. A start strobe in that same cycle has the same effect on the user index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 4 | Test mode code |
| inj_i | input | 2 | Injection point code |
| invert_i | input | 1 | Complement the line output |
| start_i | input | 1 | Restart the user-word sequence |
| user_i | input | 4x16 | User words; index 0 is word 1 |
| norm8_i | input | 8 | Normal data ahead of the scrambler |
| norm10_i | input | 10 | Normal data after the encoder |
| out8_o | output | 8 | Byte-path output |
| out10_o | output | 10 | Line-path output |

## Verification
Two restart sources can hit the user-word index in the same cycle: a mode change and a start strobe. The bench provokes this by switching from the repeating user mode into the one-shot mode with start high in the same cycle. It also pulses start in the middle of the PRBS and toggle modes, where start must have no effect. A sweep over every mode, injection code and invert setting includes these pulses. In every case the bench compares the outputs with words built from a cycle count it keeps separately for each restart source.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int PRBS_MAXLEN = 23;
    localparam int NUM_USER    = 4;

    typedef enum logic [3:0] {
        MD_NORMAL = 4'b0000,
        MD_CHECK  = 4'b0001,
        MD_TOGGLE = 4'b0010,
        MD_PN23   = 4'b0011,
        MD_PN9    = 4'b0100,
        MD_URPT   = 4'b0101,
        MD_USGL   = 4'b0110,
        MD_PN7    = 4'b1100,
        MD_PN15   = 4'b1101
    } tpg_mode_e;

    typedef enum logic [1:0] {
        INJ_OFF  = 2'b00,
        INJ_LINE = 2'b01,
        INJ_BYTE = 2'b10,
        INJ_RSVD = 2'b11
    } tpg_inj_e;

    typedef struct packed {
        logic [PRBS_MAXLEN-1:0] lfsr;
        logic [2:0]             idx;
        logic                   ph;
    } tpg_state_t;

    localparam tpg_state_t STATE_SEED = '{lfsr: '1, idx: 3'd0, ph: 1'b1};

    function automatic logic mode_known(input logic [3:0] m);
        case (m)
            MD_CHECK, MD_TOGGLE, MD_PN23, MD_PN9,
            MD_URPT, MD_USGL, MD_PN7, MD_PN15: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic [PRBS_MAXLEN-1:0] prbs_mask(input logic [3:0] m);
        case (m)
            MD_PN7:  return PRBS_MAXLEN'(23'h00007F);
            MD_PN9:  return PRBS_MAXLEN'(23'h0001FF);
            MD_PN15: return PRBS_MAXLEN'(23'h007FFF);
            MD_PN23: return PRBS_MAXLEN'(23'h7FFFFF);
            default: return '0;
        endcase
    endfunction

    function automatic logic [PRBS_MAXLEN-1:0] prbs_step(
        input logic [PRBS_MAXLEN-1:0] s, input logic [3:0] m);
        logic fb;
        case (m)
            MD_PN7:  fb = s[6]  ^ s[5];
            MD_PN9:  fb = s[8]  ^ s[4];
            MD_PN15: fb = s[14] ^ s[13];
            MD_PN23: fb = s[22] ^ s[17];
            default: return s;
        endcase
        return {s[PRBS_MAXLEN-2:0], fb};
    endfunction

endpackage

// File: rtl/tpg_gen.sv
module tpg_gen
    import tpg_pkg::*;
#(
    parameter int W  = 8,
    parameter int UW = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [3:0]                   mode_i,
    input  logic                         chg_i,
    input  logic                         start_i,
    input  logic [NUM_USER-1:0][UW-1:0]  user_i,
    output logic [W-1:0]                 pat_o
);

    function automatic logic [W-1:0] chk_word();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = (((W - 1 - i) % 2) == 0);
        return v;
    endfunction

    localparam logic [W-1:0] CHK_WORD = chk_word();

    tpg_state_t st_q, base, nxt;
    logic [W-1:0] prbs_w;

    always_comb begin
        base = st_q;
        if (chg_i)   base = STATE_SEED;
        if (start_i) base.idx = 3'd0;

        nxt    = base;
        nxt.ph = ~base.ph;
        if (mode_i == MD_URPT)
            nxt.idx = {1'b0, base.idx[1:0] + 2'd1};
        else if (mode_i == MD_USGL && base.idx < 3'd4)
            nxt.idx = base.idx + 3'd1;

        prbs_w = '0;
        for (int i = 0; i < W; i++) begin
            nxt.lfsr        = prbs_step(nxt.lfsr, mode_i);
            prbs_w[W-1-i]   = nxt.lfsr[0];
        end

        case (mode_i)
            MD_CHECK:                          pat_o = CHK_WORD;
            MD_TOGGLE:                         pat_o = {W{base.ph}};
            MD_PN7, MD_PN9, MD_PN15, MD_PN23:  pat_o = prbs_w;
            MD_URPT, MD_USGL:
                pat_o = (base.idx < 3'd4) ? user_i[base.idx[1:0]][UW-1 -: W] : '0;
            default:                           pat_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= STATE_SEED;
        else     st_q <= nxt;
    end

    AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_TOGGLE && !chg_i && !$past(rst) && $past(mode_i) == MD_TOGGLE)
        |-> (pat_o == ~$past(pat_o))); // R4

    AST_PRBS_LIVE: assert property (@(posedge clk) disable iff (rst)
        ((prbs_mask(mode_i) != '0) && !chg_i)
        |-> ((st_q.lfsr & prbs_mask(mode_i)) != '0)); // R5

    AST_RPT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_URPT && !chg_i && !start_i && !$past(rst)
         && $past(mode_i) == MD_URPT && !$past(chg_i) && !$past(start_i))
        |-> (st_q.idx[1:0] == $past(st_q.idx[1:0]) + 2'd1)); // R6

    AST_SINGLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_USGL && !chg_i && !start_i && st_q.idx == 3'd4)
        |-> (pat_o == '0)); // R7

endmodule

// File: rtl/tpg_mux.sv
module tpg_mux
    import tpg_pkg::*;
#(
    parameter int NW = 8,
    parameter int WW = 10
) (
    input  logic [3:0]    mode_i,
    input  logic [1:0]    inj_i,
    input  logic          invert_i,
    input  logic [NW-1:0] pat8_i,
    input  logic [WW-1:0] pat10_i,
    input  logic [NW-1:0] norm8_i,
    input  logic [WW-1:0] norm10_i,
    output logic [NW-1:0] out8_o,
    output logic [WW-1:0] out10_o
);

    logic          active;
    logic [WW-1:0] line_w;

    always_comb begin
        active  = mode_known(mode_i);
        out8_o  = (active && inj_i == INJ_BYTE) ? pat8_i : norm8_i;
        line_w  = (active && inj_i == INJ_LINE) ? pat10_i : norm10_i;
        out10_o = line_w ^ {WW{invert_i}};
    end

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 10,
    parameter int UW       = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [3:0]                  mode_i,
    input  logic [1:0]                  inj_i,
    input  logic                        invert_i,
    input  logic                        start_i,
    input  logic [NUM_USER-1:0][UW-1:0] user_i,
    input  logic [NARROW_W-1:0]         norm8_i,
    input  logic [WIDE_W-1:0]           norm10_i,
    output logic [NARROW_W-1:0]         out8_o,
    output logic [WIDE_W-1:0]           out10_o
);

    localparam int NUM_PATH = 2;

    logic [3:0]                       mode_q;
    logic                             chg;
    logic [NUM_PATH-1:0][WIDE_W-1:0]  pats;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_NORMAL;
        else     mode_q <= mode_i;
    end

    assign chg = (mode_i != mode_q);

    for (genvar g = 0; g < NUM_PATH; g++) begin : g_path
        localparam int GW = (g == 0) ? NARROW_W : WIDE_W;
        logic [GW-1:0] pg;
        tpg_gen #(.W(GW), .UW(UW)) u_gen (
            .clk     (clk),
            .rst     (rst),
            .mode_i  (mode_i),
            .chg_i   (chg),
            .start_i (start_i),
            .user_i  (user_i),
            .pat_o   (pg)
        );
        assign pats[g] = WIDE_W'(pg);
    end

    tpg_mux #(.NW(NARROW_W), .WW(WIDE_W)) u_mux (
        .mode_i   (mode_i),
        .inj_i    (inj_i),
        .invert_i (invert_i),
        .pat8_i   (pats[0][NARROW_W-1:0]),
        .pat10_i  (pats[1]),
        .norm8_i  (norm8_i),
        .norm10_i (norm10_i),
        .out8_o   (out8_o),
        .out10_o  (out10_o)
    );

    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (rst)
        !mode_known(mode_i)
        |-> (out8_o == norm8_i && out10_o == (norm10_i ^ {WIDE_W{invert_i}}))); // R10

    AST_INV_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (invert_i && inj_i != INJ_LINE) |-> (out10_o == ~norm10_i)); // R9

    AST_BYTE_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (inj_i != INJ_BYTE) |-> (out8_o == norm8_i)); // R2

endmodule

// File: tb/tb_tpg_top.sv
`timescale 1ns/1ps
module tb_tpg_top;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       mode = 4'd0;
    logic [1:0]       inj = 2'd0;
    logic             inv = 1'b0;
    logic             start = 1'b0;
    logic [3:0][15:0] uw;
    logic [7:0]       n8 = 8'd0;
    logic [9:0]       n10 = 10'd0;
    logic [7:0]       o8;
    logic [9:0]       o10;

    int checks = 0;
    int errors = 0;
    int kp = 0;
    int ku = 0;
    int cyc = 0;
    logic [3:0] prev = 4'd0;

    always #5 clk = ~clk;

    tpg_top dut (
        .clk(clk), .rst(rst), .mode_i(mode), .inj_i(inj), .invert_i(inv),
        .start_i(start), .user_i(uw), .norm8_i(n8), .norm10_i(n10),
        .out8_o(o8), .out10_o(o10)
    );

    function automatic bit known(input logic [3:0] m);
        return (m inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd12, 4'd13});
    endfunction

    function automatic logic [9:0] prbs_word(input logic [3:0] m, input int k, input int w);
        int n, b;
        logic [22:0] s;
        logic [9:0]  r;
        logic        bit_v;
        case (m)
            4'd12:   begin n = 7;  b = 6;  end
            4'd4:    begin n = 9;  b = 5;  end
            4'd13:   begin n = 15; b = 14; end
            default: begin n = 23; b = 18; end
        endcase
        s = (23'h1 << n) - 23'h1;
        r = '0;
        for (int i = 0; i < k * w + w; i++) begin
            bit_v = s[n-1] ^ s[b-1];
            s = ((s << 1) | 23'(bit_v)) & ((23'h1 << n) - 23'h1);
            if (i >= k * w) r[w - 1 - (i - k * w)] = bit_v;
        end
        return r;
    endfunction

    function automatic logic [9:0] exp_pat(input logic [3:0] m, input int w, input int p, input int u);
        logic [9:0] mask;
        mask = (10'h1 << w) - 10'h1;
        case (m)
            4'd1: return 10'h2AA & mask;                      // R3
            4'd2: return ((p % 2) == 0) ? mask : 10'h0;       // R4
            4'd3, 4'd4, 4'd12, 4'd13: return prbs_word(m, p, w); // R5
            4'd5: return 10'(uw[u % 4] >> (16 - w));          // R6, R8 top bits
            4'd6: return (u < 4) ? 10'(uw[u] >> (16 - w)) : 10'h0; // R7
            default: return 10'h0;
        endcase
    endfunction

    function automatic string tag(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd5: return "R6/R8";
            4'd6: return "R7";
            4'd3, 4'd4, 4'd12, 4'd13: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic step(input logic [3:0] m, input logic [1:0] ij, input logic iv, input logic st);
        logic [7:0] e8;
        logic [9:0] e10;
        @(negedge clk);
        mode = m; inj = ij; inv = iv; start = st;
        cyc++;
        n8  = 8'(cyc * 37 + 5);
        n10 = 10'(cyc * 91 + 3);
        if (m != prev) begin kp = 0; ku = 0; end   // R11 restart on change
        else begin
            kp++;
            ku = st ? 0 : ku + 1;
        end
        prev = m;
        #1;
        e8  = (known(m) && ij == 2'b10) ? exp_pat(m, 8, kp, ku)[7:0] : n8;   // R2
        e10 = ((known(m) && ij == 2'b01) ? exp_pat(m, 10, kp, ku) : n10) ^ {10{iv}}; // R9
        checks++;
        if (o8 !== e8) begin
            errors++;
            $display("FAIL %s R2 byte mode %h inj %0d act %h exp %h", tag(m), m, ij, o8, e8);
        end
        checks++;
        if (o10 !== e10) begin
            errors++;
            $display("FAIL %s R9 line mode %h inj %0d inv %0d act %h exp %h", tag(m), m, ij, iv, o10, e10);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        uw[0] = 16'hC3A5; uw[1] = 16'h5A0F; uw[2] = 16'h9E71; uw[3] = 16'h2BD4;
        repeat (3) @(negedge clk);
        #1;
        checks++;                                   // R1 reset state
        if (o8 !== n8 || o10 !== n10) begin
            errors++;
            $display("FAIL R1 reset act %h/%h exp %h/%h", o8, o10, n8, n10);
        end
        @(negedge clk);
        rst = 1'b0;
        step(4'd0, 2'd0, 1'b0, 1'b0);               // R1
        // sweep all modes, injection codes and invert, with start pulses
        for (int m = 0; m < 16; m++)
            for (int ij = 0; ij < 4; ij++)
                for (int iv = 0; iv < 2; iv++)
                    for (int c = 0; c < 6; c++)
                        step(4'(m), 2'(ij), 1'(iv), (iv == 1 && c == 3));
        // R11: mode change and start in the same cycle
        for (int c = 0; c < 3; c++) step(4'd5, 2'd2, 1'b0, 1'b0);
        step(4'd6, 2'd2, 1'b0, 1'b1);
        for (int c = 0; c < 6; c++) step(4'd6, 2'd1, 1'b1, 1'b0);
        step(4'd6, 2'd1, 1'b0, 1'b1);               // R7 restart after zeros
        for (int c = 0; c < 4; c++) step(4'd6, 2'd2, 1'b0, 1'b0);
        // R11: PRBS reseed on direct switches, start has no effect
        for (int c = 0; c < 5; c++) step(4'd12, 2'd2, 1'b0, 1'b0);
        step(4'd13, 2'd1, 1'b0, 1'b1);
        for (int c = 0; c < 5; c++) step(4'd13, 2'd1, 1'b0, (c == 2));
        for (int c = 0; c < 4; c++) step(4'd12, 2'd1, 1'b1, 1'b0);
        step(4'd7, 2'd1, 1'b1, 1'b0);               // R10
        step(4'd15, 2'd2, 1'b0, 1'b0);              // R10
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule